// File: doc/BRIEF.md
# Vector Register Slide Unit

This block moves the elements of one vector register group into another by a fixed or scalar-given distance. It supports four operations: slide toward higher indices by an offset, slide toward lower indices by an offset, and the two one-step variants that shift by exactly one position and insert a scalar value at the vacated end. A register group spans 1, 2, 4 or 8 consecutive registers, which the group size (LMUL) selects. Elements are 8, 16, 32 or 64 bits wide, which the element width (SEW) selects. The operation runs over the first vl elements of the group.

An operation is issued with a single-cycle start strobe. On that strobe the unit checks whether the register numbers are legal and latches every operand, including the mask register contents. If the operation is legal, it then walks the elements one per cycle. In each cycle it reads one source element through the register-file read port, which returns data in the same cycle, and writes one destination element through the write port. The walk runs in increasing index order for every operation except the one-step slide toward higher indices, which walks in decreasing order. That order keeps in-place operation correct without a whole-group buffer, so a debugger can build a vector inside one register by repeatedly sliding a scalar in. The unit ends every operation with a one-cycle done pulse. An illegal operation writes nothing and is reported on the illegal flag together with that pulse.

Top module: `vslide_unit`

## Requirements
- R1: Offset slide-up (op code 0): each active destination element i, with offset <= i < vl, receives source element i-offset. Destination elements with i below the offset are not written.
- R2: Offset slide-down (op code 1): each active destination element i < vl receives source element i+offset when i+offset < VLMAX, and zero otherwise. VLMAX = (VLEN/SEW)*LMUL. The offset is unsigned and may be as large as 2^64-1. The result is correct when the destination group equals the source group.
- R3: One-step slide-down (op code 3): active element vl-1 receives the low SEW bits of the scalar. Every other active element i < vl-1 receives source element i+1. The result is correct in place.
- R4: One-step slide-up (op code 2): active element 0 receives the low SEW bits of the scalar. Every other active element i < vl receives source element i-1. Elements are processed in decreasing index order, so the result is correct in place.
- R5: For op code 0, the operation is illegal when the destination group equals the source group. It is also illegal when masking is enabled and the destination group contains register 0.
- R6: For op codes 1, 2 and 3, a destination group equal to the source group is legal. The operation is illegal only when the destination group contains register 0 and LMUL > 1.
- R7: The LMUL code (0..3) selects a group size of 1, 2, 4 or 8 registers. A destination or source register number that is not a multiple of the group size makes the operation illegal.
- R8: An illegal operation writes no element. Its done pulse comes in the cycle after the start strobe, with the illegal flag high in that same cycle. The illegal flag is low at every other time.
- R9: Elements with index >= vl are never written. A vl above VLMAX is treated as VLMAX. The SEW code (0..3) selects an element width of 8, 16, 32 or 64 bits, and element i of a group lies in register base + i/(VLEN/SEW), at bit offset (i mod (VLEN/SEW))*SEW.
- R10: With masking enabled, element i is active only if bit i of register 0 is 1, sampled at the start strobe. Inactive elements keep their old value. With masking disabled, every element below vl is active.
- R11: A legal operation with effective vl = n > 0 writes its last element on the n-th rising edge after the start edge, and raises done for exactly one cycle right after that edge. An operation with n = 0 raises done in the cycle after the start strobe. Busy is high from the start edge until done ends, and reset leaves busy, done and illegal low with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe, taken only while idle |
| op | input | 2 | 0 slide-up, 1 slide-down, 2 one-step up, 3 one-step down |
| vd | input | 5 | Destination group base register |
| vs2 | input | 5 | Source group base register |
| offset | input | 64 | Unsigned slide distance for op codes 0 and 1 |
| scalar | input | 64 | Value inserted by op codes 2 and 3 |
| mask_en | input | 1 | 1 enables masking by register 0 |
| sew | input | 2 | Element width code, 8 << sew bits |
| lmul | input | 2 | Group size code, 1 << lmul registers |
| vl | input | 7 | Number of elements to process |
| v0_bits | input | 64 | Current contents of register 0 |
| rf_rd_reg | output | 5 | Read port register number |
| rf_rd_elem | output | 3 | Read port element slot within the register |
| rf_rd_data | input | 64 | Read data, zero-extended element, same cycle |
| rf_wr_en | output | 1 | Write port enable, written at the rising edge |
| rf_wr_reg | output | 5 | Write port register number |
| rf_wr_elem | output | 3 | Write port element slot within the register |
| rf_wr_data | output | 64 | Write data, low SEW bits significant |
| rf_sew | output | 2 | Element width code of the running operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal operation, valid with done |

## Verification
The bench drives each operation half a cycle before the start edge. It then counts falling edges until done appears, and expects done on the first one for illegal or empty operations and on falling edge n+1 for n effective elements. The illegal flag is sampled in that same half cycle. Once done is seen, the final write has already landed at the preceding rising edge, so the whole register-file model is compared against a bench-computed image derived from a snapshot taken before the strobe. Because the compare covers every register, it also confirms that elements beyond vl, masked-off elements, elements below the slide-up offset and all registers outside the destination group are unchanged.

// File: rtl/vslide_pkg.sv
package vslide_pkg;
  typedef enum logic [1:0] {
    SL_UP    = 2'd0,
    SL_DOWN  = 2'd1,
    SL_UP1   = 2'd2,
    SL_DOWN1 = 2'd3
  } slide_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } slide_st_e;
endpackage

// File: rtl/vslide_legal.sv
module vslide_legal
  import vslide_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  slide_op_e        op,
  input  logic [REG_W-1:0] vd,
  input  logic [REG_W-1:0] vs2,
  input  logic             mask_en,
  input  logic [1:0]       lmul,
  output logic             misaligned,
  output logic             group_clash,
  output logic             v0_clash,
  output logic             illegal
);
  logic [REG_W-1:0] low_m;
  logic             dest_has_v0;

  assign low_m       = ~({REG_W{1'b1}} << lmul);
  assign misaligned  = (|(vd & low_m)) | (|(vs2 & low_m));
  assign dest_has_v0 = ((vd & ~low_m) == '0);

  always_comb begin
    if (op == SL_UP) begin
      group_clash = ((vd & ~low_m) == (vs2 & ~low_m));
      v0_clash    = mask_en & dest_has_v0;
    end else begin
      group_clash = 1'b0;
      v0_clash    = dest_has_v0 & (lmul != 2'd0);
    end
  end

  assign illegal = misaligned | group_clash | v0_clash;
endmodule

// File: rtl/vslide_iter.sv
module vslide_iter
  import vslide_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_ok,
  input  logic            skip,
  input  logic            descend,
  input  logic [VL_W-1:0] vl_in,
  output logic [VL_W-1:0] idx,
  output logic            run,
  output logic            last,
  output logic            fin,
  output logic            idle
);
  slide_st_e       st;
  logic [VL_W-1:0] vl_q;
  logic            desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      vl_q   <= '0;
      desc_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_ok) begin
          vl_q   <= vl_in;
          desc_q <= descend;
          if (skip) st <= ST_FIN;
          else begin
            st  <= ST_RUN;
            idx <= descend ? vl_in - VL_W'(1) : '0;
          end
        end
        ST_RUN: begin
          if (last) st <= ST_FIN;
          else idx <= desc_q ? idx - VL_W'(1) : idx + VL_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign run  = (st == ST_RUN);
  assign fin  = (st == ST_FIN);
  assign idle = (st == ST_IDLE);
  assign last = desc_q ? (idx == '0) : (idx == vl_q - VL_W'(1));
endmodule

// File: rtl/vslide_dp.sv
module vslide_dp
  import vslide_pkg::*;
#(
  parameter int VLEN  = 64,
  parameter int ELEN  = 64,
  parameter int XLEN  = 64,
  parameter int REG_W = 5,
  parameter int VL_W  = 7,
  parameter int SEL_W = 3
) (
  input  slide_op_e        op,
  input  logic [REG_W-1:0] vd,
  input  logic [REG_W-1:0] vs2,
  input  logic [XLEN-1:0]  off,
  input  logic [ELEN-1:0]  scalar,
  input  logic             mask_en,
  input  logic [VLEN-1:0]  mask,
  input  logic [1:0]       sew,
  input  logic [VL_W-1:0]  vlmax,
  input  logic [VL_W-1:0]  vl,
  input  logic [VL_W-1:0]  idx,
  input  logic             run,
  input  logic [ELEN-1:0]  rd_data,
  output logic [REG_W-1:0] rd_reg,
  output logic [SEL_W-1:0] rd_elem,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_reg,
  output logic [SEL_W-1:0] wr_elem,
  output logic [ELEN-1:0]  wr_data,
  output logic             take_scalar,
  output logic             src_in_range,
  output logic             elem_active
);
  localparam int LOG_EPR8 = $clog2(VLEN / 8);

  function automatic logic [REG_W-1:0] grp_reg(logic [REG_W-1:0] base,
                                               logic [VL_W-1:0] i, logic [1:0] s);
    return base + REG_W'(i >> (LOG_EPR8 - int'(s)));
  endfunction

  function automatic logic [SEL_W-1:0] slot_of(logic [VL_W-1:0] i, logic [1:0] s);
    logic [VL_W-1:0] m;
    m = ~({VL_W{1'b1}} << (LOG_EPR8 - int'(s)));
    return SEL_W'(i & m);
  endfunction

  function automatic logic [ELEN-1:0] width_mask(logic [1:0] s);
    logic [ELEN-1:0] m;
    m = '1;
    return m >> (ELEN - (8 << s));
  endfunction

  logic [XLEN:0]   idx_w, sum_dn;
  logic            up_ok, dn_ok, use_src;
  logic [VL_W-1:0] src_idx, rd_idx;
  logic [VLEN-1:0] mask_sh;

  assign idx_w  = (XLEN + 1)'(idx);
  assign sum_dn = idx_w + {1'b0, off};
  assign up_ok  = (idx_w >= {1'b0, off});
  assign dn_ok  = (sum_dn < (XLEN + 1)'(vlmax));

  always_comb begin
    case (op)
      SL_UP:   src_idx = idx - VL_W'(off);
      SL_DOWN: src_idx = VL_W'(sum_dn);
      SL_UP1:  src_idx = idx - VL_W'(1);
      default: src_idx = idx + VL_W'(1);
    endcase
  end

  assign take_scalar  = ((op == SL_UP1) && (idx == '0)) ||
                        ((op == SL_DOWN1) && (idx == vl - VL_W'(1)));
  assign src_in_range = (op == SL_UP) ? up_ok : (op == SL_DOWN) ? dn_ok : 1'b1;
  assign use_src      = src_in_range & ~take_scalar;
  assign rd_idx       = use_src ? src_idx : idx;

  assign mask_sh     = mask >> idx;
  assign elem_active = ~mask_en | mask_sh[0];

  assign rd_reg  = grp_reg(vs2, rd_idx, sew);
  assign rd_elem = slot_of(rd_idx, sew);
  assign wr_reg  = grp_reg(vd, idx, sew);
  assign wr_elem = slot_of(idx, sew);
  assign wr_en   = run & elem_active & ~((op == SL_UP) & ~up_ok);

  always_comb begin
    if (take_scalar) wr_data = scalar & width_mask(sew);
    else if (!src_in_range) wr_data = '0;
    else wr_data = rd_data & width_mask(sew);
  end
endmodule

// File: rtl/vslide_unit.sv
module vslide_unit
  import vslide_pkg::*;
#(
  parameter int VLEN = 64,
  parameter int ELEN = 64,
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    op,
  input  logic [$clog2(NREG)-1:0]       vd,
  input  logic [$clog2(NREG)-1:0]       vs2,
  input  logic [XLEN-1:0]               offset,
  input  logic [ELEN-1:0]               scalar,
  input  logic                          mask_en,
  input  logic [1:0]                    sew,
  input  logic [1:0]                    lmul,
  input  logic [$clog2(VLEN):0]         vl,
  input  logic [VLEN-1:0]               v0_bits,
  output logic [$clog2(NREG)-1:0]       rf_rd_reg,
  output logic [$clog2(VLEN/8)-1:0]     rf_rd_elem,
  input  logic [ELEN-1:0]               rf_rd_data,
  output logic                          rf_wr_en,
  output logic [$clog2(NREG)-1:0]       rf_wr_reg,
  output logic [$clog2(VLEN/8)-1:0]     rf_wr_elem,
  output logic [ELEN-1:0]               rf_wr_data,
  output logic [1:0]                    rf_sew,
  output logic                          busy,
  output logic                          done,
  output logic                          illegal
);
  localparam int REG_W = $clog2(NREG);
  localparam int VL_W  = $clog2(VLEN) + 1;
  localparam int SEL_W = $clog2(VLEN / 8);

  slide_op_e        op_in, op_q;
  logic [VL_W-1:0]  vlmax_in, vl_eff_in, vlmax_q, vl_q, idx;
  logic             ill_now, misaligned, group_clash, v0_clash;
  logic             start_ok, run, last, fin, idle;
  logic [REG_W-1:0] vd_q, vs2_q;
  logic [XLEN-1:0]  off_q;
  logic [ELEN-1:0]  scal_q;
  logic             men_q, ill_q;
  logic [VLEN-1:0]  mask_q;
  logic [1:0]       sew_q;
  logic             take_scalar, src_in_range, elem_active;

  assign op_in     = slide_op_e'(op);
  assign vlmax_in  = VL_W'(((VLEN / 8) >> sew) << lmul);
  assign vl_eff_in = (vl > vlmax_in) ? vlmax_in : vl;
  assign start_ok  = start & idle;

  vslide_legal #(.REG_W(REG_W)) legal_i (
    .op(op_in), .vd(vd), .vs2(vs2), .mask_en(mask_en), .lmul(lmul),
    .misaligned(misaligned), .group_clash(group_clash), .v0_clash(v0_clash),
    .illegal(ill_now)
  );

  vslide_iter #(.VL_W(VL_W)) iter_i (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
    .skip(ill_now | (vl_eff_in == '0)), .descend(op_in == SL_UP1),
    .vl_in(vl_eff_in), .idx(idx), .run(run), .last(last), .fin(fin), .idle(idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= SL_UP;
      vd_q    <= '0;
      vs2_q   <= '0;
      off_q   <= '0;
      scal_q  <= '0;
      men_q   <= 1'b0;
      mask_q  <= '0;
      sew_q   <= '0;
      vlmax_q <= '0;
      vl_q    <= '0;
      ill_q   <= 1'b0;
    end else if (start_ok) begin
      op_q    <= op_in;
      vd_q    <= vd;
      vs2_q   <= vs2;
      off_q   <= offset;
      scal_q  <= scalar;
      men_q   <= mask_en;
      mask_q  <= v0_bits;
      sew_q   <= sew;
      vlmax_q <= vlmax_in;
      vl_q    <= vl_eff_in;
      ill_q   <= ill_now;
    end
  end

  vslide_dp #(
    .VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN),
    .REG_W(REG_W), .VL_W(VL_W), .SEL_W(SEL_W)
  ) dp_i (
    .op(op_q), .vd(vd_q), .vs2(vs2_q), .off(off_q), .scalar(scal_q),
    .mask_en(men_q), .mask(mask_q), .sew(sew_q), .vlmax(vlmax_q), .vl(vl_q),
    .idx(idx), .run(run), .rd_data(rf_rd_data),
    .rd_reg(rf_rd_reg), .rd_elem(rf_rd_elem), .wr_en(rf_wr_en),
    .wr_reg(rf_wr_reg), .wr_elem(rf_wr_elem), .wr_data(rf_wr_data),
    .take_scalar(take_scalar), .src_in_range(src_in_range),
    .elem_active(elem_active)
  );

  assign rf_sew  = sew_q;
  assign busy    = ~idle;
  assign done    = fin;
  assign illegal = fin & ill_q;
endmodule

// File: rtl/vslide_unit_chk.sv
module vslide_unit_chk #(
  parameter int VLEN = 64,
  parameter int XLEN = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_ok,
  input logic                 ill_now,
  input logic                 run,
  input logic [$clog2(VLEN):0] idx,
  input logic [1:0]           op_q,
  input logic [XLEN-1:0]      off_q,
  input logic                 men_q,
  input logic [VLEN-1:0]      mask_q,
  input logic [$clog2(VLEN):0] vl_q,
  input logic                 done,
  input logic                 illegal,
  input logic                 rf_wr_en
);
  localparam int VL_W = $clog2(VLEN) + 1;

  logic [VLEN-1:0] mask_at;
  assign mask_at = mask_q >> idx;

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_flag_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  a_r8_illegal_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && ill_now) |=> (!run && !rf_wr_en && done && illegal));

  a_r9_write_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (idx < vl_q));

  a_r1_keep_below_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && op_q == 2'd0) |-> (XLEN'(idx) >= off_q));

  a_r10_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en && men_q) |-> mask_at[0]);

  a_r4_descending_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && op_q == 2'd2) |-> (idx == VL_W'($past(idx) - 1'b1)));

  a_r2_ascending_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && op_q != 2'd2) |-> (idx == VL_W'($past(idx) + 1'b1)));
endmodule

bind vslide_unit vslide_unit_chk #(.VLEN(VLEN), .XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .ill_now(ill_now),
  .run(run), .idx(idx), .op_q(op_q), .off_q(off_q), .men_q(men_q),
  .mask_q(mask_q), .vl_q(vl_q), .done(done), .illegal(illegal),
  .rf_wr_en(rf_wr_en)
);

// File: tb/vslide_unit_tb.sv
`timescale 1ns/1ps
module vslide_unit_tb_top;
  typedef logic [63:0] rf_t [32];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [4:0]  vd = '0, vs2 = '0;
  logic [63:0] offset = '0, scalar = '0;
  logic        mask_en = 1'b0;
  logic [1:0]  sew = '0, lmul = '0;
  logic [6:0]  vl = '0;
  logic [4:0]  rf_rd_reg, rf_wr_reg;
  logic [2:0]  rf_rd_elem, rf_wr_elem;
  logic [63:0] rf_rd_data, rf_wr_data;
  logic        rf_wr_en, busy, done, illegal;
  logic [1:0]  rf_sew;

  rf_t  rf, seed_rf;
  logic load_req = 1'b0;
  int   errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  vslide_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd), .vs2(vs2),
    .offset(offset), .scalar(scalar), .mask_en(mask_en), .sew(sew),
    .lmul(lmul), .vl(vl), .v0_bits(rf[0]), .rf_rd_reg(rf_rd_reg),
    .rf_rd_elem(rf_rd_elem), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_reg(rf_wr_reg), .rf_wr_elem(rf_wr_elem), .rf_wr_data(rf_wr_data),
    .rf_sew(rf_sew), .busy(busy), .done(done), .illegal(illegal)
  );

  function automatic logic [63:0] wmask(int s);
    return (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  function automatic logic [63:0] get_el(rf_t r, int base, int i, int s);
    int per = 8 >> s;
    return (r[(base + i / per) % 32] >> ((i % per) * (8 << s))) & wmask(s);
  endfunction

  function automatic rf_t put_el(rf_t r, int base, int i, int s, logic [63:0] v);
    int per = 8 >> s;
    int sh = (i % per) * (8 << s);
    int rg = base + i / per;
    r[rg] = (r[rg] & ~(wmask(s) << sh)) | ((v & wmask(s)) << sh);
    return r;
  endfunction

  // Register-file model: same-cycle read, write at the rising edge
  always_comb rf_rd_data = (rf[rf_rd_reg] >> (int'(rf_rd_elem) * (8 << rf_sew))) & wmask(int'(rf_sew));

  always @(posedge clk) begin
    if (load_req) begin
      for (int r = 0; r < 32; r++) rf[r] <= seed_rf[r];
    end else if (rf_wr_en) begin
      rf[rf_wr_reg] <= (rf[rf_wr_reg] & ~(wmask(int'(rf_sew)) << (int'(rf_wr_elem) * (8 << rf_sew))))
                     | ((rf_wr_data & wmask(int'(rf_sew))) << (int'(rf_wr_elem) * (8 << rf_sew)));
    end
  end

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic rf_t model(rf_t old, int o, int d, int s2, logic [63:0] off,
                                logic [63:0] sc, bit men, int s, int vlmax, int n);
    rf_t e = old;
    for (int i = 0; i < n; i++) begin
      logic [64:0] far;
      if (men && !old[0][i]) continue;
      case (o)
        0: if ({1'b0, off} <= 65'(i)) e = put_el(e, d, i, s, get_el(old, s2, i - int'(off), s));
        1: begin
          far = 65'(i) + {1'b0, off};
          e = put_el(e, d, i, s, (far < 65'(vlmax)) ? get_el(old, s2, int'(far), s) : 64'd0);
        end
        2: e = put_el(e, d, i, s, (i == 0) ? sc : get_el(old, s2, i - 1, s));
        default: e = put_el(e, d, i, s, (i == n - 1) ? sc : get_el(old, s2, i + 1, s));
      endcase
    end
    return e;
  endfunction

  task automatic reload();
    @(negedge clk);
    for (int r = 0; r < 32; r++) seed_rf[r] = {$urandom(), $urandom()};
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic run_op(int o, int d, int s2, logic [63:0] off, logic [63:0] sc,
                        bit men, int s, int lm, int n_in, string tag);
    rf_t old, expv;
    int  grp, vlmax, n, k, bad;
    bit  ill;
    @(negedge clk);
    old   = rf;
    grp   = 1 << lm;
    vlmax = (8 >> s) << lm;
    n     = (n_in > vlmax) ? vlmax : n_in;
    ill   = (d % grp != 0) || (s2 % grp != 0) ||
            ((o == 0) ? ((d == s2) || (men && d == 0)) : (d == 0 && grp > 1));
    expv  = ill ? old : model(old, o, d, s2, off, sc, men, s, vlmax, n);
    op = 2'(o); vd = 5'(d); vs2 = 5'(s2); offset = off; scalar = sc;
    mask_en = men; sew = 2'(s); lmul = 2'(lm); vl = 7'(n_in);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    chk(k == ((ill || n == 0) ? 1 : n + 1), "R11", {tag, " done cycle"},
        longint'(k), longint'((ill || n == 0) ? 1 : n + 1));
    chk(illegal == ill, "R8", {tag, " illegal flag"}, longint'(illegal), longint'(ill));
    bad = -1;
    for (int r = 31; r >= 0; r--) if (rf[r] !== expv[r]) bad = r;
    chk(bad < 0, tag, "register file image", (bad < 0) ? 0 : rf[bad], (bad < 0) ? 0 : expv[bad]);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) seed_rf[r] = {$urandom(32'd7331), $urandom()};
    load_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    load_req = 1'b0;
    // R11: reset state
    chk(!busy && !done && !illegal && !rf_wr_en, "R11", "reset outputs",
        {busy, done, illegal, rf_wr_en}, 0);
    rst_n = 1'b1;

    // Directed corner cases
    run_op(0, 8, 16, 64'd2, 0, 0, 0, 1, 16, "R1");
    run_op(0, 8, 16, 64'd20, 0, 0, 0, 1, 16, "R1");
    run_op(1, 4, 4, 64'd3, 0, 0, 1, 2, 16, "R2");
    run_op(1, 4, 6, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 1, 16, "R2");
    for (int j = 0; j < 4; j++)
      run_op(3, 12, 12, 0, 64'h1111_2222_3333_4400 + 64'(j), 0, 0, 0, 8, "R3");
    run_op(2, 12, 12, 0, 64'hABCD_EF01_2345_6789, 0, 2, 2, 8, "R4");
    run_op(0, 8, 8, 64'd1, 0, 0, 0, 3, 8, "R5");
    run_op(0, 0, 8, 64'd1, 0, 1, 0, 0, 8, "R5");
    run_op(0, 0, 1, 64'd1, 0, 0, 0, 0, 8, "R5");
    run_op(1, 0, 8, 64'd1, 0, 0, 0, 1, 8, "R6");
    run_op(3, 0, 0, 0, 64'h5A, 1, 0, 0, 8, "R6");
    run_op(2, 8, 8, 0, 64'h77, 0, 1, 3, 30, "R6");
    run_op(1, 8, 3, 64'd1, 0, 0, 0, 2, 8, "R7");
    run_op(2, 6, 8, 0, 64'h1, 0, 0, 2, 8, "R7");
    run_op(1, 8, 16, 64'd1, 0, 0, 3, 0, 5, "R9");
    run_op(0, 8, 16, 64'd0, 0, 0, 0, 0, 0, "R9");
    run_op(0, 8, 16, 64'd1, 0, 1, 0, 1, 16, "R10");
    run_op(3, 20, 20, 0, 64'h99, 1, 0, 2, 20, "R10");

    // Constrained random mix
    for (int t = 0; t < 240; t++) begin
      int lm, g, d, s2, s, o, vmax;
      logic [63:0] off;
      if (t % 16 == 0) reload();
      lm = $urandom % 4;
      g = 1 << lm;
      s = $urandom % 4;
      o = $urandom % 4;
      d = ($urandom % (32 / g)) * g;
      s2 = ($urandom % 4 == 0) ? d : ($urandom % (32 / g)) * g;
      if ($urandom % 10 == 0) d = (d + 1) % 32;
      if ($urandom % 10 == 0) s2 = (s2 + 1) % 32;
      vmax = (8 >> s) << lm;
      off = ($urandom % 10 == 0) ? {$urandom(), $urandom()} : 64'($urandom % (vmax + 2));
      run_op(o, d, s2, off, {$urandom(), $urandom()}, bit'($urandom % 2), s, lm,
             $urandom % (vmax + 3), (o == 0) ? "R1" : (o == 1) ? "R2" : (o == 2) ? "R4" : "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule